// File: doc/BRIEF.md
# Port-Side I/O Address Decoder with Data Registers

This block sits on the device side of a multiplexed 8-bit processor bus. It watches the shared address/data byte, the address-latch strobe, the I/O-select line and the active-low read and write strobes. It implements a small group of consecutive 8-bit ports starting at a configurable port number. During the first bus period the port number travels on the shared byte, and the block captures it while the latch strobe is high. Later strobes in the same cycle act on that captured number.

On a matching I/O read, the block drives the input byte of the addressed port onto the bus while the read strobe stays low. On a matching I/O write, it takes the byte present on the bus while the write strobe is low and commits it to that port's output register when the strobe returns high. The block can also emulate a slow device: a programmable count holds the READY line low for that many clock cycles after a matching strobe begins.

Memory cycles, where I/O-select is 0, leave the block untouched. Only the captured 8-bit port number is decoded.

Top module: `io_port_slave`

## Requirements
- R1: After reset, every output register reads 00h, the captured port number reads 00h, the bus output enable is 0 and READY is 1.
- R2: The shared byte is captured into the port-number register on each rising clock edge where the latch strobe is 1. The register holds its value while the latch strobe is 0.
- R3: When I/O-select is 0, the block does not drive the bus, does not change any output register and keeps READY at 1.
- R4: While the read strobe is 0, the write strobe is 1, I/O-select is 1 and the captured number lies within the port range, the output enable is 1. In that state the bus output equals the input byte of port (number − PORT_BASE), where port k occupies bits [8k+7:8k] of the input vector. The enable falls in the same cycle that the read strobe returns high.
- R5: A captured number outside PORT_BASE .. PORT_BASE+NUM_PORTS−1 (modulo 256) causes no bus drive, no register change and no wait.
- R6: On a matching write, the output register of port (number − PORT_BASE), bits [8k+7:8k] of the output vector, takes the last byte sampled while the write strobe was 0. The new value is visible after the first rising edge at which the write strobe is sampled high again.
- R7: The rising edge that first samples a matching strobe at 0 loads the wait count. READY is then 0 for exactly that many following clock cycles. A count of 0 keeps READY at 1.
- R8: A write changes exactly one port register. All other ports keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Shared address/data byte as seen on the bus |
| bus_out | output | 8 | Byte the block places on the bus during a read |
| bus_oe | output | 1 | Output enable for bus_out |
| ale | input | 1 | Address-latch strobe, active high |
| io_sel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wait_cfg | input | WAIT_W | Number of wait cycles to request |
| ready | output | 1 | READY, low requests wait periods |
| in_bytes | input | 8*NUM_PORTS | Input bytes of all ports |
| out_bytes | output | 8*NUM_PORTS | Output registers of all ports |
| cap_addr | output | 8 | Captured port number |

## Verification
The bench targets the first port number below the range and the first one above it, where an off-by-one decoder would drive the bus or corrupt a register. It runs writes with I/O-select at 0, which would clobber a register if the select were not checked. Wait counts of 0, 1 and the maximum are used: an early or late count release would show READY at the wrong cycle, and a count of 0 that still dropped READY for one cycle would be caught. The enable is sampled right after the read strobe rises, so an enable registered one cycle late would be seen fighting the master.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

  typedef logic [7:0] byte_t;

  // Offset of a port number from the first port of the group, modulo 256.
  function automatic byte_t port_offset(input byte_t num, input byte_t base);
    port_offset = num - base;
  endfunction

endpackage

// File: rtl/io_addr_latch.sv
module io_addr_latch
  import io_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ale,
  input  byte_t bus_in,
  output byte_t cap_addr
);

  byte_t addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ale) addr_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign cap_addr = addr_q;

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(cap_addr));
  a_r2_capture_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> cap_addr == $past(bus_in));

endmodule

// File: rtl/io_port_decode.sv
module io_port_decode
  import io_port_pkg::*;
#(
  parameter int          NUM_PORTS = 4,
  parameter logic [7:0]  PORT_BASE = 8'h40,
  localparam int         IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  byte_t            cap_addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  localparam logic [8:0] RANGE = 9'(NUM_PORTS);

  byte_t off;

  always_comb begin
    off = port_offset(cap_addr, PORT_BASE);
    hit = {1'b0, off} < RANGE;
    idx = off[IDX_W-1:0];
  end

endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_act,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              ready
);

  logic              act_q, act_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              start;

  always_comb begin
    start = strobe_act && !act_q;
    act_d = strobe_act;
    cnt_d = cnt_q;
    if (start)              cnt_d = wait_cfg;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign ready = (cnt_q == '0);

  a_r7_wait_begins: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wait_cfg != '0) |=> !ready);
  a_r7_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wait_cfg == '0) |=> ready);
  a_r7_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !start) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/io_port_regs.sv
module io_port_regs
  import io_port_pkg::*;
#(
  parameter int  NUM_PORTS = 4,
  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_n,
  input  logic                   rd_n,
  input  logic                   io_sel,
  input  logic                   hit,
  input  logic [IDX_W-1:0]       idx,
  input  byte_t                  bus_in,
  output logic [8*NUM_PORTS-1:0] out_bytes
);

  logic             low_q, low_d;
  logic             match_q, match_d;
  byte_t            data_q, data_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             commit;
  logic [NUM_PORTS-1:0] port_we;

  always_comb begin
    low_d   = !wr_n;
    match_d = match_q;
    data_d  = data_q;
    idx_d   = idx_q;
    if (!wr_n) begin
      match_d = io_sel && hit && rd_n;
      data_d  = bus_in;
      idx_d   = idx;
    end
    commit = wr_n && low_q && match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= 1'b0;
      match_q <= 1'b0;
      data_q  <= '0;
      idx_q   <= '0;
    end else begin
      low_q   <= low_d;
      match_q <= match_d;
      data_q  <= data_d;
      idx_q   <= idx_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    byte_t reg_q, reg_d;
    assign port_we[p] = commit && (idx_q == IDX_W'(p));

    always_comb begin
      reg_d = reg_q;
      if (port_we[p]) reg_d = data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else        reg_q <= reg_d;
    end

    assign out_bytes[8*p +: 8] = reg_q;
  end

  a_r8_single_port_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_we));
  a_r6_stable_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(out_bytes));

endmodule

// File: rtl/io_port_slave.sv
module io_port_slave
  import io_port_pkg::*;
#(
  parameter int         NUM_PORTS = 4,
  parameter logic [7:0] PORT_BASE = 8'h40,
  parameter int         WAIT_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             bus_in,
  output logic [7:0]             bus_out,
  output logic                   bus_oe,
  input  logic                   ale,
  input  logic                   io_sel,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [WAIT_W-1:0]      wait_cfg,
  output logic                   ready,
  input  logic [8*NUM_PORTS-1:0] in_bytes,
  output logic [8*NUM_PORTS-1:0] out_bytes,
  output logic [7:0]             cap_addr
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             strobe_act;
  byte_t            in_arr [NUM_PORTS];

  io_addr_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .bus_in   (bus_in),
    .cap_addr (cap_addr)
  );

  io_port_decode #(.NUM_PORTS(NUM_PORTS), .PORT_BASE(PORT_BASE)) u_dec (
    .cap_addr (cap_addr),
    .hit      (hit),
    .idx      (idx)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_in
    assign in_arr[p] = in_bytes[8*p +: 8];
  end

  always_comb begin
    bus_oe     = !rd_n && wr_n && io_sel && hit;
    bus_out    = in_arr[idx];
    strobe_act = io_sel && hit && (rd_n != wr_n);
  end

  io_wait_gen #(.WAIT_W(WAIT_W)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_act (strobe_act),
    .wait_cfg   (wait_cfg),
    .ready      (ready)
  );

  io_port_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .io_sel    (io_sel),
    .hit       (hit),
    .idx       (idx),
    .bus_in    (bus_in),
    .out_bytes (out_bytes)
  );

  a_r3_no_drive_in_memory_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel |-> !bus_oe);
  a_r4_release_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !bus_oe);
  a_r3_memory_cycle_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !io_sel) |=> ready);

endmodule

// File: tb/sim_io_port_slave.sv
module sim_io_port_slave;

  localparam int         NP   = 4;
  localparam logic [7:0] BASE = 8'h40;
  localparam int         WW   = 4;

  logic            clk;
  logic            rst_n;
  logic [7:0]      bus_in;
  logic [7:0]      bus_out;
  logic            bus_oe;
  logic            ale, io_sel, rd_n, wr_n;
  logic [WW-1:0]   wait_cfg;
  logic            ready;
  logic [8*NP-1:0] in_bytes;
  logic [8*NP-1:0] out_bytes;
  logic [7:0]      cap_addr;

  logic [7:0]      model [NP];
  int              checks = 0;
  int              errors = 0;

  io_port_slave #(.NUM_PORTS(NP), .PORT_BASE(BASE), .WAIT_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ale(ale), .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .wait_cfg(wait_cfg),
    .ready(ready), .in_bytes(in_bytes), .out_bytes(out_bytes), .cap_addr(cap_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit in_range(logic [7:0] a);
    logic [7:0] off = a - BASE;
    return off < 8'(NP);
  endfunction

  function automatic logic [8*NP-1:0] model_vec();
    logic [8*NP-1:0] v;
    for (int p = 0; p < NP; p++) v[8*p +: 8] = model[p];
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_cycle(bit is_wr, logic [7:0] addr, logic [7:0] data, bit io, int nwait);
    bit   match;
    int   hold;
    int   idx;
    @(negedge clk);
    ale = 1'b1; bus_in = addr; io_sel = io; wait_cfg = WW'(nwait);
    @(negedge clk);
    ale = 1'b0;
    chk(cap_addr == addr, "R2 captured port number", cap_addr, addr);
    bus_in = is_wr ? data : 8'hA5;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    match = io && in_range(addr);
    idx   = int'(8'(addr - BASE));
    #1;
    chk(bus_oe == (!is_wr && match), "R4/R3/R5 output enable at strobe", bus_oe, !is_wr && match);
    if (!is_wr && match)
      chk(bus_out == in_bytes[8*idx +: 8], "R4 read data", bus_out, in_bytes[8*idx +: 8]);
    hold = (match && nwait > 0) ? nwait + 1 : 2;
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk); #1;
      chk(ready == !(match && k <= nwait), "R7 ready timing", ready, !(match && k <= nwait));
      chk(cap_addr == addr, "R2 port number held", cap_addr, addr);
      if (!is_wr && match)
        chk(bus_oe && bus_out == in_bytes[8*idx +: 8], "R4 drive while strobe low",
            {bus_oe, bus_out}, {1'b1, in_bytes[8*idx +: 8]});
    end
    rd_n = 1'b1; wr_n = 1'b1;
    #1;
    chk(bus_oe == 1'b0, "R4 enable released with strobe", bus_oe, 0);
    if (is_wr && match) model[idx] = data;
    @(negedge clk); #1;
    chk(out_bytes == model_vec(), "R6/R8/R3/R5 output registers", out_bytes, model_vec());
    chk(ready == 1'b1, "R7 ready idle", ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_in = '0; ale = 1'b0; io_sel = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    wait_cfg = '0; in_bytes = 32'h11223344;
    for (int p = 0; p < NP; p++) model[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_bytes == '0, "R1 output registers reset", out_bytes, 0);
    chk(cap_addr == 8'h00, "R1 port number reset", cap_addr, 0);
    chk(bus_oe == 1'b0, "R1 bus not driven", bus_oe, 0);
    chk(ready == 1'b1, "R1 ready high", ready, 1);

    // Directed corner cases
    bus_cycle(1, 8'h40, 8'h5A, 1, 0);   // R6 write port 0, no wait
    bus_cycle(1, 8'h43, 8'hC3, 1, 1);   // R6 last port, one wait
    bus_cycle(1, 8'h3F, 8'hEE, 1, 2);   // R5 just below range
    bus_cycle(1, 8'h44, 8'hEE, 1, 2);   // R5 just above range
    bus_cycle(1, 8'h41, 8'h99, 0, 3);   // R3 memory cycle ignored
    bus_cycle(0, 8'h42, 8'h00, 1, 15);  // R4 read, maximum wait R7
    bus_cycle(0, 8'h42, 8'h00, 0, 4);   // R3 memory read ignored
    bus_cycle(0, 8'h44, 8'h00, 1, 0);   // R5 read above range
    bus_cycle(1, 8'h41, 8'h7E, 1, 0);   // R8 only port 1 changes

    // Random stimulus
    for (int n = 0; n < 150; n++) begin
      logic [7:0] a;
      in_bytes = $urandom;
      if ($urandom % 8 == 0) a = 8'($urandom);
      else                   a = BASE + 8'($urandom % 6) - 8'd1;
      bus_cycle(bit'($urandom % 2), a, 8'($urandom), ($urandom % 4) != 0, int'($urandom % 4));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule